// File: doc/BRIEF.md
# Mains-Locked Staircase Burst Power Controller

This block sets the average power delivered to a resistive load by allowing or blocking whole mains cycles. A one-clock event marks the start of every full mains cycle. A prescaler divides those events, and each divided tick advances a 4-bit staircase code through 16 levels. The code then wraps back to its first level. With the prescaler at 2 cycles per step, one staircase sweep lasts 32 mains cycles (640 ms at 50 Hz). The long variant uses 4 cycles per step, so a sweep lasts 64 cycles (1280 ms).

At every cycle event the block compares the staircase level in force with an unsigned setpoint. It registers the result as a fire-enable flag. That flag holds for the whole mains cycle that follows, and a downstream gate-pulse stage uses it to fire the triac. The fraction of enabled cycles per sweep grows linearly with the setpoint.

The setpoint is one bit wider than the staircase code, so both full off and full on can be reached.

Top module: `burst_ramp_ctrl`

## Requirements
- R1: A synchronous active-low reset, sampled on the rising clock edge, clears the staircase code, the prescaler and `fire_en` to zero.
- R2: With `long_sel` = 0, `ramp_step` advances by one on the clock edge of every second `cyc_evt`, counted from reset.
- R3: With `long_sel` = 1, `ramp_step` advances by one on the clock edge of every fourth `cyc_evt`, counted from reset.
- R4: `ramp_step` runs 0,1,…,15 and then returns to 0 without skipping a level. A sweep is therefore 32 events long in the base variant and 64 events long in the long variant.
- R5: On each `cyc_evt` edge, `fire_en` is loaded with 1 when the code in force before that edge, zero-extended to 5 bits, is less than `setpoint`, and with 0 otherwise. Over one sweep the number of enabled cycles is the cycles-per-step times min(setpoint, 16).
- R6: A `setpoint` of 0 never sets `fire_en`.
- R7: A `setpoint` of 16 or more sets `fire_en` on every event.
- R8: Between events, `fire_en` and `ramp_step` hold their values, and changes on `setpoint` have no effect until the next `cyc_evt`.
- R9: When `long_sel` is lowered while the prescaler holds a count at or above the base step length, the next event completes the current step. That event advances `ramp_step` by one and restarts the prescaler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_evt | input | 1 | One-clock pulse at the start of each full mains cycle |
| long_sel | input | 1 | 0: 2 cycles per step, 1: 4 cycles per step |
| setpoint | input | 5 | Unsigned power demand, 0 to 31 |
| fire_en | output | 1 | Fire permission for the current mains cycle |
| ramp_step | output | 4 | Current staircase level |

## Verification
A prescaler that is out of step shows up on `ramp_step` as an advance that comes one or more events early or late. The first step boundary of a sweep exposes it, within two events in the base variant or four in the long variant. A corrupted or skipping staircase code makes the next `ramp_step` value depart from the strict +1 sequence. It also changes the count of enabled cycles over the sweep, so the fault is visible at the sweep end. An error in the comparison or its latch makes `fire_en` wrong on the very event where the level crosses the setpoint. The same error also shows at the extreme setpoints of 0, 16 and 31.

// File: rtl/burst_ramp_pkg.sv
// Package: shared definitions for the staircase burst controller.
// Assumes: the staircase code width and the per-variant step lengths are
// fixed at elaboration time; only the variant choice is dynamic.
package burst_ramp_pkg;

    // Variant encoding carried on the long_sel pin.
    typedef enum logic {
        RAMP_SHORT = 1'b0,
        RAMP_LONG  = 1'b1
    } ramp_variant_e;

    // Default staircase geometry.
    localparam int DEF_CODE_W   = 4;
    localparam int DEF_SHORT_DIV = 2;
    localparam int DEF_LONG_DIV  = 4;

endpackage

// File: rtl/burst_prescaler.sv
// Module: burst_prescaler
// Divides mains-cycle events into staircase step ticks. The division ratio
// is SHORT_DIV or LONG_DIV cycles, chosen by the variant input.
// Assumes: cyc_evt is a single-clock pulse; LONG_DIV >= SHORT_DIV >= 1.
// When the ratio shrinks mid-step, a count at or above the new limit wraps on
// the next event.
module burst_prescaler
    import burst_ramp_pkg::*;
#(
    parameter int SHORT_DIV = DEF_SHORT_DIV,
    parameter int LONG_DIV  = DEF_LONG_DIV
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_evt,
    input  ramp_variant_e variant,
    output logic          step_tick
);
    localparam int PRE_W = (LONG_DIV > 1) ? $clog2(LONG_DIV) : 1;
    localparam logic [PRE_W-1:0] SHORT_LIM = PRE_W'(SHORT_DIV - 1);
    localparam logic [PRE_W-1:0] LONG_LIM  = PRE_W'(LONG_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;
    logic             at_end;

    // Select the terminal count for the active variant.
    always_comb begin
        lim    = (variant == RAMP_LONG) ? LONG_LIM : SHORT_LIM;
        at_end = (pre_q >= lim);
    end

    // Count events within a step and restart once the step is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (cyc_evt) begin
            pre_q <= at_end ? '0 : pre_q + PRE_W'(1);
        end
    end

    // Emit the step tick on the event that completes a step.
    always_comb step_tick = cyc_evt && at_end;

    // A completed step always restarts the count at zero (R2, R3, R9).
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        step_tick |=> (pre_q == '0));

    // The count moves only on a mains-cycle event (R8).
    p_pre_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_evt |=> $stable(pre_q));

endmodule

// File: rtl/burst_stair_counter.sv
// Module: burst_stair_counter
// Holds the staircase level and advances it by one per step tick, wrapping
// from the top level back to the first.
// Assumes: step_tick is at most one clock long per event.
module burst_stair_counter
    import burst_ramp_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_tick,
    output logic [CODE_W-1:0] code
);
    // Advance the level on each tick; natural overflow gives the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
        end else if (step_tick) begin
            code <= code + CODE_W'(1);
        end
    end

    // Every tick moves exactly one level, including the top-to-zero wrap (R4).
    p_step_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step_tick |=> (code == ($past(code) + CODE_W'(1))));

    // No tick, no movement (R8).
    p_step_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !step_tick |=> $stable(code));

endmodule

// File: rtl/burst_fire_gate.sv
// Module: burst_fire_gate
// Compares the staircase level with the setpoint once per mains cycle and
// holds the verdict for the whole cycle.
// Assumes: the setpoint is one bit wider than the code, so that values of
// 2**CODE_W and above enable every level.
module burst_fire_gate
    import burst_ramp_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W,
    parameter int SET_W  = CODE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_evt,
    input  logic [CODE_W-1:0] code,
    input  logic [SET_W-1:0]  setpoint,
    output logic              fire_en
);
    localparam int FULL_LVL = 1 << CODE_W;

    logic allow;

    // Firing is allowed while the level is below the demand.
    always_comb allow = ({{(SET_W-CODE_W){1'b0}}, code} < setpoint);

    // Latch the verdict at the start of each mains cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire_en <= 1'b0;
        end else if (cyc_evt) begin
            fire_en <= allow;
        end
    end

    // Zero demand never fires (R6).
    p_never_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_evt && (setpoint == '0)) |=> !fire_en);

    // Full demand fires on every cycle (R7).
    p_always_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_evt && (int'(setpoint) >= FULL_LVL)) |=> fire_en);

    // The verdict is frozen between events (R8).
    p_fire_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_evt |=> $stable(fire_en));

endmodule

// File: rtl/burst_ramp_ctrl.sv
// Module: burst_ramp_ctrl (top)
// Burst-firing power controller. Mains-cycle events drive a prescaler, which
// steps a staircase code. A per-cycle compare of that code against the
// setpoint gives a fire enable for a downstream gate-pulse stage.
// Assumes: cyc_evt is a clean, synchronized one-clock pulse per mains cycle.
// All state uses a synchronous active-low reset.
module burst_ramp_ctrl
    import burst_ramp_pkg::*;
#(
    parameter int CODE_W    = DEF_CODE_W,
    parameter int SHORT_DIV = DEF_SHORT_DIV,
    parameter int LONG_DIV  = DEF_LONG_DIV,
    parameter int SET_W     = CODE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_evt,
    input  logic              long_sel,
    input  logic [SET_W-1:0]  setpoint,
    output logic              fire_en,
    output logic [CODE_W-1:0] ramp_step
);
    ramp_variant_e     variant;
    logic              step_tick;
    logic [CODE_W-1:0] code;

    // Map the variant pin onto the shared encoding.
    always_comb variant = ramp_variant_e'(long_sel);

    burst_prescaler #(
        .SHORT_DIV (SHORT_DIV),
        .LONG_DIV  (LONG_DIV)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_evt   (cyc_evt),
        .variant   (variant),
        .step_tick (step_tick)
    );

    burst_stair_counter #(
        .CODE_W (CODE_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_tick (step_tick),
        .code      (code)
    );

    burst_fire_gate #(
        .CODE_W (CODE_W),
        .SET_W  (SET_W)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_evt  (cyc_evt),
        .code     (code),
        .setpoint (setpoint),
        .fire_en  (fire_en)
    );

    // Expose the staircase level.
    always_comb ramp_step = code;

    // A level advance happens only on an event edge (R8).
    p_adv_on_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_step != $past(ramp_step)) |-> $past(cyc_evt));

endmodule

// File: tb/burst_ramp_ctrl_tb.sv
module burst_ramp_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_evt = 1'b0;
    logic       long_sel = 1'b0;
    logic [4:0] setpoint = '0;
    logic       fire_en;
    logic [3:0] ramp_step;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_ramp_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_evt   (cyc_evt),
        .long_sel  (long_sel),
        .setpoint  (setpoint),
        .fire_en   (fire_en),
        .ramp_step (ramp_step)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    // One event pulse; returns after the capturing edge, away from it.
    task automatic do_event();
        @(negedge clk) cyc_evt = 1'b1;
        @(negedge clk) cyc_evt = 1'b0;
    endtask

    // R1: reset state.
    task automatic t_reset();
        do_reset();
        chk("R1 step", ramp_step, 0);
        chk("R1 fire", fire_en, 0);
    endtask

    // Full sweep with constant variant and setpoint (R2/R3/R4/R5/R6/R7).
    task automatic t_sweep(input bit lng, input int sp, input string req);
        int per = lng ? 4 : 2;
        int fired = 0;
        int bad_step = 0;
        int bad_fire = 0;
        int on_lvls = (sp > 16) ? 16 : sp;
        long_sel = lng;
        setpoint = 5'(sp);
        do_reset();
        for (int k = 0; k < 16 * per; k++) begin
            do_event();
            if (fire_en) fired++;
            if (int'(ramp_step) != ((k + 1) / per) % 16) begin
                if (bad_step == 0)
                    chk({req, " step"}, ramp_step, ((k + 1) / per) % 16);
                bad_step++;
            end
            if (int'(fire_en) != int'(((k / per) % 16) < sp)) begin
                if (bad_fire == 0)
                    chk({req, " fire"}, fire_en, int'(((k / per) % 16) < sp));
                bad_fire++;
            end
        end
        chk({req, " step mismatches"}, bad_step, 0);
        chk({req, " fire mismatches"}, bad_fire, 0);
        chk({req, " fired cycles"}, fired, per * on_lvls);
        chk({req, " R4 back at level 0"}, ramp_step, 0);
    endtask

    // R8: setpoint and time between events change nothing.
    task automatic t_hold();
        long_sel = 1'b0;
        setpoint = 5'd1;
        do_reset();
        do_event();
        chk("R8 fire after event", fire_en, 1);
        setpoint = 5'd0;
        repeat (6) @(negedge clk);
        chk("R8 fire held", fire_en, 1);
        chk("R8 step held", ramp_step, 0);
        do_event();
        chk("R8 new setpoint used at event", fire_en, 0);
        chk("R8 step after 2nd event", ramp_step, 1);
    endtask

    // R9: shrinking the step length mid-step.
    task automatic t_switch();
        long_sel = 1'b1;
        setpoint = 5'd3;
        do_reset();
        repeat (3) do_event();
        chk("R9 still level 0", ramp_step, 0);
        long_sel = 1'b0;
        do_event();
        chk("R9 step completes", ramp_step, 1);
        do_event();
        chk("R9 restart first", ramp_step, 1);
        do_event();
        chk("R9 restart second", ramp_step, 2);
        // R1: mid-run reset
        do_reset();
        chk("R1 mid-run step", ramp_step, 0);
        chk("R1 mid-run fire", fire_en, 0);
    endtask

    initial begin
        t_reset();
        t_sweep(1'b0, 5,  "R2/R5 base sp5");
        t_sweep(1'b1, 9,  "R3/R5 long sp9");
        t_sweep(1'b0, 0,  "R6 sp0");
        t_sweep(1'b1, 0,  "R6 long sp0");
        t_sweep(1'b0, 16, "R7 sp16");
        t_sweep(1'b1, 31, "R7 long sp31");
        t_sweep(1'b0, 15, "R4/R5 sp15");
        t_hold();
        t_switch();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule